// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is one pulse-width-modulation channel. A 24-bit counter runs on a dedicated timer clock and advances once per prescaler tick. The tick rate is the timer clock divided by 1, 16, 256 or 2048. The counter climbs from 0 to a programmed period value and then clears. The output sits in its active phase while the count is below a programmed duty value. A polarity bit decides whether the active phase is driven high or low. A duty of 0 holds the output inactive for the whole period. A duty above the period holds it active for the whole period. At divide-by-1 and a 48 MHz timer clock, one count step lasts about 20.83 ns.

Software reaches the channel through a simple word-addressed write/read port on its own bus clock. The bus clock and the timer clock are unrelated, and either one may be the faster. Any write to the control, period or duty register marks the configuration dirty. A bus-side handshake machine then moves a snapshot of all four configuration fields into the timer domain. The machine has three states:

- `X_IDLE` goes to `X_REQ` when a transfer is pending.
- `X_REQ` goes to `X_DROP` once the synchronised acknowledge is seen.
- `X_DROP` goes back to `X_IDLE` once the acknowledge has dropped.

The timer side has two states:

- `C_STOP` holds the counter and prescaler at 0 and drives the polarity level. It takes a new snapshot at once and moves to `C_RUN` if that snapshot has the run bit set.
- `C_RUN` counts. It takes a new snapshot only at a counter clear, and it returns to `C_STOP` if that snapshot has the run bit clear.

Three events set sticky status bits in the bus domain: an output rising edge, an output falling edge and a counter clear. Each status bit has an enable bit. The interrupt line is the OR of all enabled pending bits.

Top module: `pwm_chan_top`

## Requirements
- R1: After reset, `pwm_out` and `irq` are 0, and every register reads 0.
- R2: At divide-by-1 with 0 < duty <= period, the output stays active for exactly duty timer clocks and inactive for exactly period+1-duty timer clocks, repeating.
- R3: CTRL bits [3:2] select the clocks per count step: 0 gives 1, 1 gives 16, 2 gives 256 and 3 gives 2048. Both phase lengths scale by that factor.
- R4: A duty of 0 keeps the output constantly inactive. A duty greater than the period keeps it constantly active.
- R5: CTRL bit 1 is the polarity. With 0 the active level is 1. With 1 the active level is 0, and the phase lengths are unchanged.
- R6: While CTRL bit 0 (run) is 0, the counter is stopped and the output equals the polarity bit. No rise, fall or clear events occur unless the polarity itself is changed. A polarity change moves the output and flags that edge.
- R7: While the channel is running, new period, duty, prescaler, polarity and run values take effect only at a counter clear.
- R8: Address 3 is the status register: bit 0 is rise, bit 1 is fall and bit 2 is clear. The bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: Address 4 holds the enable bits, in the same bit positions as the status register. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R10: Address 0 reads back {run, polarity, select} in bits [3:0]. Addresses 1 and 2 read back the 24-bit period and duty. Unused addresses read 0.
- R11: Configuration crosses correctly whether the bus clock is slower or faster than the timer clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Register bus clock |
| brst_n | input | 1 | Bus-domain reset, active low |
| reg_wr | input | 1 | Write strobe, one bus cycle per write |
| reg_addr | input | 3 | Word address (0 CTRL, 1 PERIOD, 2 DUTY, 3 STATUS, 4 ENABLE) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | OR of enabled pending status bits |
| tclk | input | 1 | Timer clock |
| trst_n | input | 1 | Timer-domain reset, active low |
| pwm_out | output | 1 | PWM output |

## Verification
If the prescaler or the counter state is wrong, the measured length of an active or inactive phase changes. That shows at `pwm_out` within a single period, so the bench measures each phase in timer clocks over a sweep of periods, duties, both polarities and all four divide settings. If the configuration is taken at the wrong moment or a handshake transfer is lost, the new pattern never appears, or a stale one persists, within the settling window. Wrong status logic appears at the next read of address 3 and on `irq`, within a few bus cycles of the event.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    localparam int CNT_W  = 24;
    localparam int SEL_W  = 2;
    localparam int PRE_W  = 11;
    localparam int N_EVT  = 3;
    localparam int DW     = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DUTY = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd4;

    localparam int EV_RISE = 0;
    localparam int EV_FALL = 1;
    localparam int EV_CLR  = 2;

    typedef struct packed {
        logic             run;
        logic             pol;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
    } cfg_t;

    typedef enum logic [1:0] {X_IDLE, X_REQ, X_DROP} xfer_st_e;
    typedef enum logic {C_STOP, C_RUN} core_st_e;

    function automatic logic [PRE_W-1:0] pre_limit(input logic [SEL_W-1:0] sel);
        logic [PRE_W-1:0] lim;
        unique case (sel)
            2'd0: lim = PRE_W'(0);
            2'd1: lim = PRE_W'(15);
            2'd2: lim = PRE_W'(255);
            default: lim = PRE_W'(2047);
        endcase
        return lim;
    endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_chan_pkg::*;
(
    input  logic              bclk,
    input  logic              brst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [N_EVT-1:0]  evt,
    output logic [DW-1:0]     rdata,
    output logic              irq,
    output cfg_t              cfg,
    output logic              cfg_wr,
    output logic [N_EVT-1:0]  status
);
    logic [N_EVT-1:0] inten;
    logic [N_EVT-1:0] clr_mask;

    assign clr_mask = (wr && addr == A_STAT) ? wdata[N_EVT-1:0] : '0;
    assign cfg_wr   = wr && (addr == A_CTRL || addr == A_PER || addr == A_DUTY);

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            cfg    <= '0;
            inten  <= '0;
            status <= '0;
        end else begin
            status <= (status & ~clr_mask) | evt;
            if (wr) begin
                unique case (addr)
                    A_CTRL: begin
                        cfg.run <= wdata[0];
                        cfg.pol <= wdata[1];
                        cfg.sel <= wdata[SEL_W+1:2];
                    end
                    A_PER:  cfg.period <= wdata[CNT_W-1:0];
                    A_DUTY: cfg.duty   <= wdata[CNT_W-1:0];
                    A_EN:   inten      <= wdata[N_EVT-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: rdata[SEL_W+1:0] = {cfg.sel, cfg.pol, cfg.run};
            A_PER:  rdata[CNT_W-1:0] = cfg.period;
            A_DUTY: rdata[CNT_W-1:0] = cfg.duty;
            A_STAT: rdata[N_EVT-1:0] = status;
            A_EN:   rdata[N_EVT-1:0] = inten;
            default: rdata = '0;
        endcase
    end

    assign irq = |(status & inten);
endmodule

// File: rtl/pwm_xfer_bus.sv
module pwm_xfer_bus
    import pwm_chan_pkg::*;
(
    input  logic     bclk,
    input  logic     brst_n,
    input  cfg_t     cfg,
    input  logic     cfg_wr,
    input  logic     ack,
    output logic     req,
    output cfg_t     hold,
    output xfer_st_e xst
);
    logic [1:0] ack_sy;
    logic       ack_s;
    logic       pending;
    logic       launch;
    xfer_st_e   xst_n;

    assign ack_s  = ack_sy[1];
    assign launch = (xst == X_IDLE) && pending;

    always_comb begin
        xst_n = xst;
        unique case (xst)
            X_IDLE: if (pending) xst_n = X_REQ;
            X_REQ:  if (ack_s)   xst_n = X_DROP;
            X_DROP: if (!ack_s)  xst_n = X_IDLE;
            default: xst_n = X_IDLE;
        endcase
    end

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            xst     <= X_IDLE;
            ack_sy  <= '0;
            pending <= 1'b0;
        end else begin
            xst     <= xst_n;
            ack_sy  <= {ack_sy[0], ack};
            pending <= (pending && !launch) || cfg_wr;
        end
    end

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            req  <= 1'b0;
            hold <= '0;
        end else begin
            req <= (xst_n == X_REQ);
            if (launch) hold <= cfg;
        end
    end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_chan_pkg::*;
(
    input  logic             tclk,
    input  logic             trst_n,
    input  logic             req,
    input  cfg_t             hold,
    output logic             ack,
    output logic             pwm_out,
    output logic [N_EVT-1:0] evt,
    output core_st_e         cst,
    output logic [CNT_W-1:0] cnt,
    output logic [PRE_W-1:0] pre,
    output cfg_t             cur,
    output logic             clr
);
    logic [1:0] req_sy;
    logic       req_s;
    cfg_t       staged;
    logic       staged_vld;
    logic       capture;
    logic       load;
    logic       tick;
    logic       active;
    logic       pwm_d;
    core_st_e   cst_n;
    logic [PRE_W-1:0] lim;

    assign req_s   = req_sy[1];
    assign capture = req_s && !ack;
    assign lim     = pre_limit(cur.sel);
    assign tick    = (cst == C_RUN) && (pre == lim);
    assign clr     = tick && (cnt == cur.period);
    assign load    = staged_vld && ((cst == C_STOP) || clr);
    assign active  = (cnt < cur.duty);

    always_comb begin
        cst_n = cst;
        unique case (cst)
            C_STOP: if (load && staged.run)  cst_n = C_RUN;
            C_RUN:  if (load && !staged.run) cst_n = C_STOP;
            default: cst_n = C_STOP;
        endcase
    end

    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) cst <= C_STOP;
        else         cst <= cst_n;
    end

    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) begin
            req_sy     <= '0;
            ack        <= 1'b0;
            staged     <= '0;
            staged_vld <= 1'b0;
            cur        <= '0;
        end else begin
            req_sy <= {req_sy[0], req};
            if (capture) begin
                staged     <= hold;
                staged_vld <= 1'b1;
                ack        <= 1'b1;
            end else begin
                if (!req_s && ack) ack <= 1'b0;
                if (load)          staged_vld <= 1'b0;
            end
            if (load) cur <= staged;
        end
    end

    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) begin
            pre <= '0;
            cnt <= '0;
        end else if (cst == C_STOP) begin
            pre <= '0;
            cnt <= '0;
        end else if (tick) begin
            pre <= '0;
            cnt <= clr ? '0 : cnt + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) begin
            pwm_out <= 1'b0;
            pwm_d   <= 1'b0;
        end else begin
            pwm_out <= (cst == C_RUN) ? (active ^ cur.pol) : cur.pol;
            pwm_d   <= pwm_out;
        end
    end

    always_comb begin
        evt          = '0;
        evt[EV_RISE] = pwm_out && !pwm_d;
        evt[EV_FALL] = !pwm_out && pwm_d;
        evt[EV_CLR]  = clr;
    end
endmodule

// File: rtl/pwm_evt_sync.sv
module pwm_evt_sync
    import pwm_chan_pkg::*;
#(
    parameter int N = N_EVT
) (
    input  logic         tclk,
    input  logic         trst_n,
    input  logic [N-1:0] evt_in,
    input  logic         bclk,
    input  logic         brst_n,
    output logic [N-1:0] evt_out
);
    for (genvar i = 0; i < N; i++) begin : g_evt
        logic       tog;
        logic [2:0] sy;

        always_ff @(posedge tclk or negedge trst_n) begin
            if (!trst_n)        tog <= 1'b0;
            else if (evt_in[i]) tog <= ~tog;
        end

        always_ff @(posedge bclk or negedge brst_n) begin
            if (!brst_n) sy <= '0;
            else         sy <= {sy[1:0], tog};
        end

        assign evt_out[i] = sy[2] ^ sy[1];
    end
endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top
    import pwm_chan_pkg::*;
(
    input  logic              bclk,
    input  logic              brst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    input  logic              tclk,
    input  logic              trst_n,
    output logic              pwm_out
);
    cfg_t             cfg;
    cfg_t             hold;
    cfg_t             cur;
    logic             cfg_wr;
    logic             req;
    logic             ack;
    logic [N_EVT-1:0] evt_t;
    logic [N_EVT-1:0] evt_b;
    logic [N_EVT-1:0] status;
    xfer_st_e         xst;
    core_st_e         cst;
    logic [CNT_W-1:0] cnt;
    logic [PRE_W-1:0] pre;
    logic             clr;

    pwm_regs u_regs (
        .bclk(bclk), .brst_n(brst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .evt(evt_b), .rdata(reg_rdata), .irq(irq),
        .cfg(cfg), .cfg_wr(cfg_wr), .status(status)
    );

    pwm_xfer_bus u_xfer (
        .bclk(bclk), .brst_n(brst_n), .cfg(cfg), .cfg_wr(cfg_wr),
        .ack(ack), .req(req), .hold(hold), .xst(xst)
    );

    pwm_core u_core (
        .tclk(tclk), .trst_n(trst_n), .req(req), .hold(hold), .ack(ack),
        .pwm_out(pwm_out), .evt(evt_t), .cst(cst), .cnt(cnt), .pre(pre),
        .cur(cur), .clr(clr)
    );

    pwm_evt_sync #(.N(N_EVT)) u_evt (
        .tclk(tclk), .trst_n(trst_n), .evt_in(evt_t),
        .bclk(bclk), .brst_n(brst_n), .evt_out(evt_b)
    );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk
    import pwm_chan_pkg::*;
(
    input logic              tclk,
    input logic              trst_n,
    input logic              bclk,
    input logic              brst_n,
    input core_st_e          cst,
    input logic [CNT_W-1:0]  cnt,
    input logic [PRE_W-1:0]  pre,
    input cfg_t              cur,
    input logic              clr,
    input logic              pwm_out,
    input xfer_st_e          xst,
    input cfg_t              hold,
    input logic [N_EVT-1:0]  status,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata
);
    logic [N_EVT-1:0] clr_req;
    assign clr_req = (wr && addr == A_STAT) ? wdata[N_EVT-1:0] : '0;

    assert_cnt_range_R2: assert property (@(posedge tclk) disable iff (!trst_n)
        (cst == C_RUN) |-> (cnt <= cur.period));

    assert_step_on_tick_R3: assert property (@(posedge tclk) disable iff (!trst_n)
        ((cst == C_RUN) && $past(cst == C_RUN) && (pre != '0)) |-> $stable(cnt));

    assert_zero_duty_R4: assert property (@(posedge tclk) disable iff (!trst_n)
        ((cst == C_RUN) && $past(cst == C_RUN) && (cur.duty == '0) &&
         ($past(cur.duty) == '0) && ($past(cur.pol) == cur.pol)) |-> (pwm_out == cur.pol));

    assert_stop_level_R6: assert property (@(posedge tclk) disable iff (!trst_n)
        (cst == C_STOP) |=> (pwm_out == $past(cur.pol)));

    assert_cfg_at_clear_R7: assert property (@(posedge tclk) disable iff (!trst_n)
        ((cst == C_RUN) && !clr) |=> $stable(cur));

    assert_sticky_R8: assert property (@(posedge bclk) disable iff (!brst_n)
        ((($past(status) & ~status) & ~$past(clr_req)) == '0));

    assert_hold_stable_R11: assert property (@(posedge bclk) disable iff (!brst_n)
        (xst != X_IDLE) |=> $stable(hold));
endmodule

bind pwm_chan_top pwm_chan_chk u_chk (
    .tclk(tclk), .trst_n(trst_n), .bclk(bclk), .brst_n(brst_n),
    .cst(cst), .cnt(cnt), .pre(pre), .cur(cur), .clr(clr), .pwm_out(pwm_out),
    .xst(xst), .hold(hold), .status(status), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata)
);

// File: tb/tb_pwm_chan_top.sv
`timescale 1ns/1ps
module tb_pwm_chan_top;
    logic        bclk = 1'b0;
    logic        tclk = 1'b0;
    logic        brst_n = 1'b0;
    logic        trst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        pwm_out;

    real bhalf = 6.5;
    int  n_chk = 0;
    int  n_fail = 0;
    int  prev_len = 1;

    always #4 tclk = ~tclk;
    always #(bhalf) bclk = ~bclk;

    pwm_chan_top dut (
        .bclk(bclk), .brst_n(brst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .tclk(tclk), .trst_n(trst_n), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge bclk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge bclk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge bclk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_t(input int n);
        repeat (n) @(negedge tclk);
    endtask

    function automatic int div_of(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 16 : (sel == 2) ? 256 : 2048;
    endfunction

    task automatic configure(input int sel, input bit pol, input bit run, input int p, input int d);
        int len;
        len = (p + 1) * div_of(sel);
        bus_write(3'd1, 32'(p));
        bus_write(3'd2, 32'(d));
        bus_write(3'd0, {28'd0, 2'(sel), pol, run});
        wait_t(prev_len + 2 * len + 200);
        prev_len = len;
    endtask

    task automatic measure(input int sel, input bit pol, input int p, input int d, input string tag);
        int  dv, a, b, bad;
        bit  act_lvl;
        dv = div_of(sel);
        act_lvl = ~pol;
        if (d == 0 || d > p) begin
            bad = 0;
            repeat (2 * (p + 1) * dv + 10) begin
                @(negedge tclk);
                if (pwm_out != ((d == 0) ? pol : act_lvl)) bad++;
            end
            check(bad == 0, {tag, " R4 constant level"}, bad, 0);
        end else begin
            @(negedge tclk);
            while (pwm_out == act_lvl) @(negedge tclk);
            while (pwm_out != act_lvl) @(negedge tclk);
            a = 0;
            while (pwm_out == act_lvl) begin a++; @(negedge tclk); end
            b = 0;
            while (pwm_out != act_lvl) begin b++; @(negedge tclk); end
            check(a == d * dv, {tag, " active length"}, a, d * dv);
            check(b == (p + 1 - d) * dv, {tag, " inactive length"}, b, (p + 1 - d) * dv);
        end
    endtask

    initial begin
        wait_t(150000);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        wait_t(5);
        brst_n = 1'b1; trst_n = 1'b1;
        wait_t(5);

        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), rd);
            check(rd == 32'd0, "R1 reset register", rd, 0);
        end
        check(pwm_out == 1'b0, "R1 reset pwm_out", pwm_out, 0);
        check(irq == 1'b0, "R1 reset irq", irq, 0);

        // R2 / R4 sweep at divide-by-1, bus clock slower than timer clock (R11)
        for (int p = 1; p <= 5; p++)
            for (int d = 0; d <= p + 1; d++) begin
                configure(0, 1'b0, 1'b1, p, d);
                measure(0, 1'b0, p, d, "R2 R11 slow bus");
            end

        // R10 readback
        configure(0, 1'b0, 1'b1, 37, 9);
        bus_read(3'd0, rd); check(rd == 32'h1, "R10 ctrl readback", rd, 1);
        bus_read(3'd1, rd); check(rd == 32'd37, "R10 period readback", rd, 37);
        bus_read(3'd2, rd); check(rd == 32'd9, "R10 duty readback", rd, 9);
        bus_read(3'd6, rd); check(rd == 32'd0, "R10 unused address", rd, 0);

        // bus clock now faster than timer clock
        bhalf = 2.0;

        // R5 polarity sweep
        for (int d = 0; d <= 4; d++) begin
            configure(0, 1'b1, 1'b1, 3, d);
            measure(0, 1'b1, 3, d, "R5 R11 fast bus");
        end

        // R3 prescaler settings
        for (int d = 0; d <= 3; d++) begin
            configure(1, 1'b0, 1'b1, 2, d);
            measure(1, 1'b0, 2, d, "R3 div16");
        end
        configure(2, 1'b1, 1'b1, 1, 1);
        measure(2, 1'b1, 1, 1, "R3 div256");
        configure(3, 1'b0, 1'b1, 1, 1);
        measure(3, 1'b0, 1, 1, "R3 div2048");

        // R8 / R9 status and interrupt
        configure(0, 1'b0, 1'b1, 20, 5);
        bus_write(3'd4, 32'h7);
        bus_write(3'd3, 32'h7);
        wait_t(100);
        bus_read(3'd3, rd);
        check(rd == 32'h7, "R8 all events flagged", rd, 7);
        check(irq == 1'b1, "R9 irq with all enabled", irq, 1);
        bus_write(3'd4, 32'h0);
        wait_t(4);
        check(irq == 1'b0, "R9 irq masked", irq, 0);
        bus_write(3'd4, 32'h4);
        wait_t(4);
        check(irq == 1'b1, "R9 irq via clear enable", irq, 1);

        configure(0, 1'b0, 1'b1, 20, 0);
        bus_write(3'd3, 32'h7);
        wait_t(100);
        bus_read(3'd3, rd);
        check(rd == 32'h4, "R8 clear only at zero duty", rd, 4);

        // R6 stop
        configure(0, 1'b0, 1'b0, 20, 5);
        bus_write(3'd3, 32'h7);
        wait_t(100);
        bus_read(3'd3, rd);
        check(rd == 32'h0, "R6 no events when stopped", rd, 0);
        check(pwm_out == 1'b0, "R6 stopped level pol0", pwm_out, 0);
        check(irq == 1'b0, "R9 irq idle", irq, 0);

        configure(0, 1'b1, 1'b0, 20, 5);
        check(pwm_out == 1'b1, "R6 stopped level pol1", pwm_out, 1);
        configure(0, 1'b0, 1'b0, 20, 5);
        bus_read(3'd3, rd);
        check(rd == 32'h3, "R6 polarity edges flagged", rd, 3);
        bus_write(3'd3, 32'h1);
        wait_t(4);
        bus_read(3'd3, rd);
        check(rd == 32'h2, "R8 partial write-one-clear", rd, 2);
        bus_write(3'd3, 32'h0);
        wait_t(4);
        bus_read(3'd3, rd);
        check(rd == 32'h2, "R8 write zero keeps bit", rd, 2);

        // R7 restart after stop, and pending change visible only after clear
        configure(0, 1'b0, 1'b1, 4, 2);
        measure(0, 1'b0, 4, 2, "R7 restart");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule